// File: doc/BRIEF.md
# Adjustable Time-of-Day Counter

This block keeps a running time of day for precision time protocol work. It holds whole seconds, a nanoseconds field, and a fraction of a nanosecond with 2^-32 ns resolution. On each reference tick it adds a nominal 40 ns. Software can trim that step with a signed sub-nanosecond addend. The addend can be a persistent setting, or a temporary one that lasts for a set number of ticks. Software can also move the time forward or backward by an offset, read the live time out atomically, or write a new time in.

All access goes through a small register bus. The bus has 32-bit words, one word index per register, and separate read and write strobes. The time offsets and the captured time share a set of shadow registers, which software reads and writes. Writing the control word starts a command, which then runs in a fixed pipeline slot. The live seconds and nanoseconds are also driven straight out on ports, so that timestamp logic nearby can use them.

Top module: `tod_clock`

## Requirements
- R1: While and after rst_n is low, the live seconds and nanoseconds are zero and every readable register reads zero.
- R2: With run enable (control bit 1) set and no rate trim active, each cycle with tick_i high adds exactly 40 ns. A cycle without tick_i leaves the time unchanged.
- R3: The nanoseconds field always stays below 1,000,000,000. An advance that reaches that value subtracts it and adds one to seconds.
- R4: The rate word (index 4) holds a magnitude in bits 29:0, in units of 2^-32 ns, and a direction in bit 31 (1 adds, 0 subtracts). When control bit 2 is set, this magnitude changes every tick by that amount. When bit 2 is clear, it has no effect.
- R5: The capture command (control bit 4) copies the live seconds and nanoseconds into shadow seconds (index 3) and shadow nanoseconds (index 2), and clears the phase (index 1, bits 2:0).
- R6: The load command (control bit 3) sets the live seconds to the shadow seconds. It sets the live nanoseconds to the shadow nanoseconds plus 8 ns times the phase, with a carry into seconds, and it clears the fraction.
- R7: The step command (control bit 6) with direction bit 5 = 1 adds the shadow seconds and the shadow nanoseconds to the live time, with a carry from nanoseconds into seconds.
- R8: The step command with bit 5 = 0 subtracts both magnitudes. When the nanoseconds would go negative, it borrows one second.
- R9: The command bits 0, 3, 4 and 6 act at the clock edge that follows the edge that writes them. They always read back as zero. A tick that falls in the same cycle as a reset, load or step command is discarded.
- R10: A rate write with bit 30 set stores a temporary rate. This rate applies whatever control bit 2 holds, for as many ticks as the duration word (index 5) held when the rate was written. The duration counts down once per applied tick. After that, the persistent rate comes back into force and bit 30 reads zero.
- R11: The clock reset command (control bit 0) clears the time, the fraction, both rates and the duration. The run enable takes the value written in the same control word.
- R12: While run enable is clear, the time holds through any ticks, but load and step commands are still applied.
- R13: The register indices on addr_i are control 0, phase 1, nanoseconds 2, seconds 3, rate 4 and duration 5. rdata_o shows the addressed word from the edge at which rd_en_i is sampled onward. Control reads return bits 1, 2 and 5 as they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick strobe, one advance per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (3) | Register word index |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| tod_sec_o | output | SEC_W (32) | Live seconds |
| tod_ns_o | output | NS_W (30) | Live nanoseconds |

## Verification
A tick advances the live time at the same edge that samples it, so the bench checks the live ports at the falling edge that follows. A command written at edge N takes effect at edge N+1. The bench therefore checks once at the falling edge between the two edges, where the old time should still hold, and once after edge N+1. Read data is registered, so it is sampled half a cycle after the edge that took rd_en_i. Reads that follow a command wait one idle cycle, so that the shadow copy has landed. A behavioural model steps alongside on every rising edge and is compared with the live ports and every read on each falling edge.

// File: rtl/tod_pkg.sv
package tod_pkg;

   // register word indices
   typedef enum logic [2:0] {
      IDX_CTRL  = 3'd0,
      IDX_PHASE = 3'd1,
      IDX_NS    = 3'd2,
      IDX_SEC   = 3'd3,
      IDX_RATE  = 3'd4,
      IDX_DUR   = 3'd5
   } tod_idx_e;

   // control word bit positions
   localparam int CB_CLR  = 0;
   localparam int CB_RUN  = 1;
   localparam int CB_TRIM = 2;
   localparam int CB_LOAD = 3;
   localparam int CB_CAPT = 4;
   localparam int CB_SDIR = 5;
   localparam int CB_STEP = 6;

   // rate word bit positions
   localparam int RB_TMP = 30;
   localparam int RB_DIR = 31;

   typedef struct packed {
      logic step;
      logic capt;
      logic load;
      logic clr;
   } tod_cmd_t;

endpackage

// File: rtl/tod_tick_adder.sv
module tod_tick_adder #(
   parameter int NS_W    = 30,
   parameter int FRAC_W  = 32,
   parameter int ADD_W   = 30,
   parameter int NOM_NS  = 40,
   parameter int NS_WRAP = 1_000_000_000
) (
   input  logic [NS_W-1:0]   ns_i,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic              add_en_i,
   input  logic              add_up_i,
   input  logic [ADD_W-1:0]  add_mag_i,
   output logic [NS_W-1:0]   ns_o,
   output logic [FRAC_W-1:0] frac_o,
   output logic              carry_o
);
   localparam int ACC_W = NS_W + FRAC_W + 1;

   logic [ACC_W-1:0] base, nominal, addend, sum;
   logic [NS_W:0]    hi;

   always_comb begin
      base    = {1'b0, ns_i, frac_i};
      nominal = ACC_W'(NOM_NS) << FRAC_W;
      addend  = add_en_i ? ACC_W'(add_mag_i) : '0;
      sum     = add_up_i ? (base + nominal + addend) : (base + nominal - addend);
      hi      = sum[ACC_W-1:FRAC_W];
      frac_o  = sum[FRAC_W-1:0];
      if (hi >= (NS_W+1)'(NS_WRAP)) begin
         carry_o = 1'b1;
         ns_o    = NS_W'(hi - (NS_W+1)'(NS_WRAP));
      end else begin
         carry_o = 1'b0;
         ns_o    = hi[NS_W-1:0];
      end
   end
endmodule

// File: rtl/tod_offset_alu.sv
module tod_offset_alu #(
   parameter int SEC_W   = 32,
   parameter int NS_W    = 30,
   parameter int NS_WRAP = 1_000_000_000
) (
   input  logic [SEC_W-1:0] sec_i,
   input  logic [NS_W-1:0]  ns_i,
   input  logic [SEC_W-1:0] off_sec_i,
   input  logic [NS_W-1:0]  off_ns_i,
   input  logic             up_i,
   output logic [SEC_W-1:0] sec_o,
   output logic [NS_W-1:0]  ns_o
);
   localparam logic [NS_W:0] WRAP = (NS_W+1)'(NS_WRAP);

   logic [NS_W:0] ns_sum;

   always_comb begin
      ns_sum = '0;
      if (up_i) begin
         ns_sum = {1'b0, ns_i} + {1'b0, off_ns_i};
         if (ns_sum >= WRAP) begin
            ns_o  = NS_W'(ns_sum - WRAP);
            sec_o = sec_i + off_sec_i + SEC_W'(1);
         end else begin
            ns_o  = ns_sum[NS_W-1:0];
            sec_o = sec_i + off_sec_i;
         end
      end else if (ns_i < off_ns_i) begin
         ns_o  = NS_W'({1'b0, ns_i} + WRAP - {1'b0, off_ns_i});
         sec_o = sec_i - off_sec_i - SEC_W'(1);
      end else begin
         ns_o  = ns_i - off_ns_i;
         sec_o = sec_i - off_sec_i;
      end
   end
endmodule

// File: rtl/tod_temp_rate.sv
module tod_temp_rate #(
   parameter int ADD_W  = 30,
   parameter int DUR_W  = 32,
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             set_i,
   input  logic             set_up_i,
   input  logic [ADD_W-1:0] set_mag_i,
   input  logic             dur_we_i,
   input  logic [DUR_W-1:0] dur_wd_i,
   input  logic             tick_i,
   output logic             on_o,
   output logic             up_o,
   output logic [ADD_W-1:0] mag_o,
   output logic [DUR_W-1:0] dur_o
);
   generate
      if (ENABLE) begin : g_timer
         logic             on_q, up_q;
         logic [ADD_W-1:0] mag_q;
         logic [DUR_W-1:0] dur_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               on_q <= 1'b0; up_q <= 1'b0; mag_q <= '0; dur_q <= '0;
            end else if (clr_i) begin
               on_q <= 1'b0; up_q <= 1'b0; mag_q <= '0; dur_q <= '0;
            end else begin
               if (dur_we_i)
                  dur_q <= dur_wd_i;
               else if (tick_i && on_q && dur_q != '0)
                  dur_q <= dur_q - DUR_W'(1);
               if (set_i) begin
                  mag_q <= set_mag_i;
                  up_q  <= set_up_i;
                  on_q  <= (dur_q != '0);
               end else if (on_q && ((tick_i && dur_q <= DUR_W'(1)) ||
                                     (dur_we_i && dur_wd_i == '0))) begin
                  on_q <= 1'b0;
               end
            end
         end

         assign on_o  = on_q;
         assign up_o  = up_q;
         assign mag_o = mag_q;
         assign dur_o = dur_q;
      end else begin : g_none
         assign on_o  = 1'b0;
         assign up_o  = 1'b0;
         assign mag_o = '0;
         assign dur_o = '0;
      end
   endgenerate
endmodule

// File: rtl/tod_clock.sv
module tod_clock
   import tod_pkg::*;
#(
   parameter int SEC_W        = 32,
   parameter int NS_W         = 30,
   parameter int FRAC_W       = 32,
   parameter int ADD_W        = 30,
   parameter int DUR_W        = 32,
   parameter int PH_W         = 3,
   parameter int PH_UNIT_NS   = 8,
   parameter int NOM_NS       = 40,
   parameter int NS_WRAP      = 1_000_000_000,
   parameter int ADDR_W       = 3,
   parameter int DATA_W       = 32,
   parameter bit TEMP_RATE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [SEC_W-1:0]  tod_sec_o,
   output logic [NS_W-1:0]   tod_ns_o
);
   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_data
      $error("tod_clock: DATA_W must be 32");
   end
   if (SEC_W > DATA_W || DUR_W > DATA_W || NS_W > DATA_W) begin : g_bad_fld
      $error("tod_clock: field wider than bus");
   end
   if (ADD_W > RB_TMP || ADD_W > FRAC_W) begin : g_bad_add
      $error("tod_clock: addend too wide");
   end
   if (longint'(NS_WRAP) + NOM_NS + (longint'(PH_UNIT_NS) << PH_W) >= (longint'(1) << NS_W)) begin : g_bad_ns
      $error("tod_clock: NS_W too narrow for wrap value");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("tod_clock: ADDR_W must be at least 3");
   end

   logic              run_q, trim_q, sdir_q;
   tod_cmd_t          pend_q;
   logic [SEC_W-1:0]  sec_q, sh_sec;
   logic [NS_W-1:0]   ns_q, sh_ns;
   logic [FRAC_W-1:0] frac_q;
   logic [PH_W-1:0]   sh_ph;
   logic              pers_up;
   logic [ADD_W-1:0]  pers_mag;
   logic [DATA_W-1:0] rd_word;

   logic wr_ctrl, wr_ph, wr_ns, wr_sec, wr_rate, wr_dur;
   logic act, tick_go;

   assign wr_ctrl = wr_en_i && addr_i == ADDR_W'(IDX_CTRL);
   assign wr_ph   = wr_en_i && addr_i == ADDR_W'(IDX_PHASE);
   assign wr_ns   = wr_en_i && addr_i == ADDR_W'(IDX_NS);
   assign wr_sec  = wr_en_i && addr_i == ADDR_W'(IDX_SEC);
   assign wr_rate = wr_en_i && addr_i == ADDR_W'(IDX_RATE);
   assign wr_dur  = wr_en_i && addr_i == ADDR_W'(IDX_DUR);

   assign act     = pend_q.clr || pend_q.load || pend_q.step;
   assign tick_go = run_q && tick_i && !act;

   // temporary rate timer
   logic             tmp_on, tmp_up;
   logic [ADD_W-1:0] tmp_mag;
   logic [DUR_W-1:0] dur_cnt;

   tod_temp_rate #(.ADD_W(ADD_W), .DUR_W(DUR_W), .ENABLE(TEMP_RATE_EN)) u_tmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (pend_q.clr),
      .set_i     (wr_rate && wdata_i[RB_TMP]),
      .set_up_i  (wdata_i[RB_DIR]),
      .set_mag_i (wdata_i[ADD_W-1:0]),
      .dur_we_i  (wr_dur),
      .dur_wd_i  (wdata_i[DUR_W-1:0]),
      .tick_i    (tick_go),
      .on_o      (tmp_on),
      .up_o      (tmp_up),
      .mag_o     (tmp_mag),
      .dur_o     (dur_cnt)
   );

   // per-tick advance
   logic [NS_W-1:0]   nx_ns;
   logic [FRAC_W-1:0] nx_frac;
   logic              nx_carry;

   tod_tick_adder #(.NS_W(NS_W), .FRAC_W(FRAC_W), .ADD_W(ADD_W),
                    .NOM_NS(NOM_NS), .NS_WRAP(NS_WRAP)) u_adv (
      .ns_i      (ns_q),
      .frac_i    (frac_q),
      .add_en_i  (tmp_on || trim_q),
      .add_up_i  (tmp_on ? tmp_up : pers_up),
      .add_mag_i (tmp_on ? tmp_mag : pers_mag),
      .ns_o      (nx_ns),
      .frac_o    (nx_frac),
      .carry_o   (nx_carry)
   );

   // load path: shadow time plus phase offset
   logic [SEC_W-1:0] ld_sec, st_sec;
   logic [NS_W-1:0]  ld_ns, st_ns;

   tod_offset_alu #(.SEC_W(SEC_W), .NS_W(NS_W), .NS_WRAP(NS_WRAP)) u_load (
      .sec_i     (sh_sec),
      .ns_i      (sh_ns),
      .off_sec_i ('0),
      .off_ns_i  (NS_W'(sh_ph) * NS_W'(PH_UNIT_NS)),
      .up_i      (1'b1),
      .sec_o     (ld_sec),
      .ns_o      (ld_ns)
   );

   // step path: live time plus or minus shadow offset
   tod_offset_alu #(.SEC_W(SEC_W), .NS_W(NS_W), .NS_WRAP(NS_WRAP)) u_step (
      .sec_i     (sec_q),
      .ns_i      (ns_q),
      .off_sec_i (sh_sec),
      .off_ns_i  (sh_ns),
      .up_i      (sdir_q),
      .sec_o     (st_sec),
      .ns_o      (st_ns)
   );

   // read mux
   always_comb begin
      rd_word = '0;
      case (addr_i)
         ADDR_W'(IDX_CTRL): begin
            rd_word[CB_RUN]  = run_q;
            rd_word[CB_TRIM] = trim_q;
            rd_word[CB_SDIR] = sdir_q;
         end
         ADDR_W'(IDX_PHASE): rd_word = DATA_W'(sh_ph);
         ADDR_W'(IDX_NS):    rd_word = DATA_W'(sh_ns);
         ADDR_W'(IDX_SEC):   rd_word = DATA_W'(sh_sec);
         ADDR_W'(IDX_RATE): begin
            rd_word[ADD_W-1:0] = tmp_on ? tmp_mag : pers_mag;
            rd_word[RB_TMP]    = tmp_on;
            rd_word[RB_DIR]    = tmp_on ? tmp_up : pers_up;
         end
         ADDR_W'(IDX_DUR):   rd_word = DATA_W'(dur_cnt);
         default:            rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         trim_q   <= 1'b0;
         sdir_q   <= 1'b0;
         pend_q   <= '0;
         sec_q    <= '0;
         ns_q     <= '0;
         frac_q   <= '0;
         sh_sec   <= '0;
         sh_ns    <= '0;
         sh_ph    <= '0;
         pers_up  <= 1'b0;
         pers_mag <= '0;
         rdata_o  <= '0;
      end else begin
         // command pulses live for one cycle only
         pend_q.step <= wr_ctrl && wdata_i[CB_STEP];
         pend_q.capt <= wr_ctrl && wdata_i[CB_CAPT];
         pend_q.load <= wr_ctrl && wdata_i[CB_LOAD];
         pend_q.clr  <= wr_ctrl && wdata_i[CB_CLR];
         if (wr_ctrl) begin
            run_q  <= wdata_i[CB_RUN];
            trim_q <= wdata_i[CB_TRIM];
            sdir_q <= wdata_i[CB_SDIR];
         end

         // shadow registers
         if (pend_q.capt) begin
            sh_sec <= sec_q;
            sh_ns  <= ns_q;
            sh_ph  <= '0;
         end else begin
            if (wr_ph)  sh_ph  <= wdata_i[PH_W-1:0];
            if (wr_ns)  sh_ns  <= wdata_i[NS_W-1:0];
            if (wr_sec) sh_sec <= wdata_i[SEC_W-1:0];
         end

         // persistent rate
         if (pend_q.clr) begin
            pers_up  <= 1'b0;
            pers_mag <= '0;
         end else if (wr_rate && !wdata_i[RB_TMP]) begin
            pers_up  <= wdata_i[RB_DIR];
            pers_mag <= wdata_i[ADD_W-1:0];
         end

         // live time, priority clear > load > step > tick
         if (pend_q.clr) begin
            sec_q  <= '0;
            ns_q   <= '0;
            frac_q <= '0;
         end else if (pend_q.load) begin
            sec_q  <= ld_sec;
            ns_q   <= ld_ns;
            frac_q <= '0;
         end else if (pend_q.step) begin
            sec_q  <= st_sec;
            ns_q   <= st_ns;
         end else if (tick_go) begin
            ns_q   <= nx_ns;
            frac_q <= nx_frac;
            sec_q  <= sec_q + SEC_W'(nx_carry);
         end

         if (rd_en_i) rdata_o <= rd_word;
      end
   end

   assign tod_sec_o = sec_q;
   assign tod_ns_o  = ns_q;

endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
   parameter int SEC_W   = 32,
   parameter int NS_W    = 30,
   parameter int NOM_NS  = 40,
   parameter int NS_WRAP = 1_000_000_000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             run_q,
   input logic             trim_q,
   input logic             tmp_on,
   input logic             act,
   input logic             p_clr,
   input logic [SEC_W-1:0] tod_sec_o,
   input logic [NS_W-1:0]  tod_ns_o
);
   logic plain_tick;
   assign plain_tick = run_q && tick_i && !act && !trim_q && !tmp_on;

   // R3
   ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tod_ns_o < NS_W'(NS_WRAP));

   // R2
   nominal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_tick && tod_ns_o < NS_W'(NS_WRAP - NOM_NS))
      |=> (tod_ns_o == $past(tod_ns_o) + NS_W'(NOM_NS)) && $stable(tod_sec_o));

   // R3
   sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_tick && tod_ns_o >= NS_W'(NS_WRAP - NOM_NS))
      |=> tod_sec_o == $past(tod_sec_o) + SEC_W'(1));

   // R12
   hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !act) |=> ($stable(tod_sec_o) && $stable(tod_ns_o)));

   // R11
   clear_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p_clr |=> (tod_sec_o == '0 && tod_ns_o == '0));

endmodule

bind tod_clock tod_clock_chk #(
   .SEC_W(SEC_W), .NS_W(NS_W), .NOM_NS(NOM_NS), .NS_WRAP(NS_WRAP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .run_q     (run_q),
   .trim_q    (trim_q),
   .tmp_on    (tmp_on),
   .act       (act),
   .p_clr     (pend_q.clr),
   .tod_sec_o (tod_sec_o),
   .tod_ns_o  (tod_ns_o)
);

// File: tb/tod_clock_tb.sv
module tod_clock_tb_top;

   localparam int A_CTRL = 0, A_PH = 1, A_NS = 2, A_SEC = 3, A_RATE = 4, A_DUR = 5;
   localparam longint TWO32 = longint'(1) << 32;
   localparam longint BILLION = 1_000_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] tsec;
   logic [29:0] tns;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   tod_clock dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .tod_sec_o(tsec), .tod_ns_o(tns)
   );

   // ---------------- behavioural reference model ----------------
   bit [31:0] m_sec, m_ssec, m_dur;
   longint    m_ns, m_frac, m_sns;
   int        m_ph;
   bit        m_run, m_trim, m_sdir;
   bit        p_clr, p_load, p_step, p_cap;
   bit        r_up, t_on, t_up;
   longint    r_mag, t_mag;
   bit [31:0] m_rd;
   bit        rd_seen;

   function automatic bit [31:0] m_read(input int a);
      bit [31:0] w;
      w = 0;
      case (a)
         A_CTRL: begin w[1] = m_run; w[2] = m_trim; w[5] = m_sdir; end
         A_PH:   w = 32'(m_ph);
         A_NS:   w = 32'(m_sns);
         A_SEC:  w = m_ssec;
         A_RATE: w = t_on ? {t_up, 1'b1, 30'(t_mag)} : {r_up, 1'b0, 30'(r_mag)};
         A_DUR:  w = m_dur;
         default: w = 0;
      endcase
      return w;
   endfunction

   always @(posedge clk) begin
      bit        act, tg, up;
      longint    acc, add, o_ns;
      bit [31:0] o_sec;
      bit        wc, wr_rate;
      if (!rst_n) begin
         m_sec = 0; m_ns = 0; m_frac = 0; m_ssec = 0; m_sns = 0; m_ph = 0;
         m_run = 0; m_trim = 0; m_sdir = 0; p_clr = 0; p_load = 0; p_step = 0; p_cap = 0;
         r_up = 0; r_mag = 0; t_on = 0; t_up = 0; t_mag = 0; m_dur = 0; m_rd = 0; rd_seen = 0;
      end else begin
         rd_seen = rd_en;
         if (rd_en) m_rd = m_read(int'(addr));
         act = p_clr || p_load || p_step;
         tg = m_run && tick && !act;
         o_sec = m_sec; o_ns = m_ns;
         wc = wr_en && addr == 3'(A_CTRL);
         wr_rate = wr_en && addr == 3'(A_RATE);
         if (p_clr) begin
            m_sec = 0; m_ns = 0; m_frac = 0;
         end else if (p_load) begin
            m_sec = m_ssec; m_ns = m_sns + 8 * m_ph; m_frac = 0;
            if (m_ns >= BILLION) begin m_ns -= BILLION; m_sec += 1; end
         end else if (p_step) begin
            if (m_sdir) begin
               m_ns = m_ns + m_sns; m_sec = m_sec + m_ssec;
               if (m_ns >= BILLION) begin m_ns -= BILLION; m_sec += 1; end
            end else begin
               m_sec = m_sec - m_ssec;
               if (m_ns < m_sns) begin m_ns = m_ns + BILLION - m_sns; m_sec -= 1; end
               else m_ns = m_ns - m_sns;
            end
         end else if (tg) begin
            up  = t_on ? t_up : r_up;
            add = t_on ? t_mag : (m_trim ? r_mag : 0);
            acc = m_ns * TWO32 + m_frac + 40 * TWO32 + (up ? add : -add);
            m_ns = acc / TWO32; m_frac = acc % TWO32;
            if (m_ns >= BILLION) begin m_ns -= BILLION; m_sec += 1; end
         end
         // rate state
         if (p_clr) begin
            r_up = 0; r_mag = 0; t_on = 0; t_up = 0; t_mag = 0; m_dur = 0;
         end else begin
            bit [31:0] od;
            bit        oon;
            od = m_dur; oon = t_on;
            if (wr_en && addr == 3'(A_DUR)) m_dur = wdata;
            else if (tg && oon && od != 0) m_dur = od - 1;
            if (wr_rate && wdata[30]) begin
               t_mag = longint'(wdata[29:0]); t_up = wdata[31]; t_on = (od != 0);
            end else if (oon && ((tg && od <= 1) || (wr_en && addr == 3'(A_DUR) && wdata == 0))) begin
               t_on = 0;
            end
            if (wr_rate && !wdata[30]) begin r_up = wdata[31]; r_mag = longint'(wdata[29:0]); end
         end
         // shadows
         if (p_cap) begin
            m_ssec = o_sec; m_sns = o_ns; m_ph = 0;
         end else if (wr_en) begin
            if (addr == 3'(A_PH))  m_ph = int'(wdata[2:0]);
            if (addr == 3'(A_NS))  m_sns = longint'(wdata[29:0]);
            if (addr == 3'(A_SEC)) m_ssec = wdata;
         end
         // control
         p_step = wc && wdata[6]; p_cap = wc && wdata[4];
         p_load = wc && wdata[3]; p_clr = wc && wdata[0];
         if (wc) begin m_run = wdata[1]; m_trim = wdata[2]; m_sdir = wdata[5]; end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (tsec != m_sec || longint'(tns) != m_ns) begin
            bad++;
            $display("FAIL R2/R3 model live time: actual %0d s %0d ns expected %0d s %0d ns",
                     tsec, tns, m_sec, m_ns);
         end
         if (rd_seen) begin
            total++;
            if (rdata != m_rd) begin
               bad++;
               $display("FAIL R13 model read: actual %h expected %h", rdata, m_rd);
            end
         end
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic wr(input int a, input bit [31:0] d);
      wr_en = 1'b1; addr = 3'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic cmd(input bit [31:0] d);
      wr(A_CTRL, d);
      @(negedge clk);
   endtask

   task automatic rd_chk(input int a, input bit [31:0] exp, input string tag);
      rd_en = 1'b1; addr = 3'(a);
      @(negedge clk);
      rd_en = 1'b0;
      total++;
      if (rdata !== exp) begin
         bad++;
         $display("FAIL %s read idx %0d: actual %h expected %h", tag, a, rdata, exp);
      end
   endtask

   task automatic live_chk(input bit [31:0] es, input bit [29:0] en, input string tag);
      total++;
      if (tsec !== es || tns !== en) begin
         bad++;
         $display("FAIL %s live: actual %0d s %0d ns expected %0d s %0d ns", tag, tsec, tns, es, en);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
      end
      tick = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      live_chk(0, 0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      live_chk(0, 0, "R1");
      rd_chk(A_CTRL, 32'h0, "R1");
      rd_chk(A_RATE, 32'h0, "R1");
      rd_chk(A_SEC, 32'h0, "R1");

      // R6 clean load, run on
      wr(A_PH, 0); wr(A_NS, 999_999_900); wr(A_SEC, 5);
      cmd(32'h0A);
      live_chk(5, 999_999_900, "R6");
      rd_chk(A_CTRL, 32'h2, "R9 R13");

      // R2 nominal advance, R3 wrap
      ticks(2);
      live_chk(5, 999_999_980, "R2");
      repeat (2) @(negedge clk);
      live_chk(5, 999_999_980, "R2 no tick");
      ticks(1);
      live_chk(6, 20, "R3");

      // R12 stopped: ticks ignored
      cmd(32'h0);
      ticks(5);
      live_chk(6, 20, "R12");

      // R7 step add with carry, while stopped (R12)
      wr(A_NS, 999_999_990); wr(A_SEC, 10);
      cmd(32'h60);
      live_chk(17, 10, "R7 R12");
      rd_chk(A_CTRL, 32'h20, "R13");

      // R8 step subtract with borrow
      wr(A_NS, 20); wr(A_SEC, 3);
      cmd(32'h40);
      live_chk(13, 999_999_990, "R8");

      // R5 capture
      wr(A_PH, 5);
      cmd(32'h10);
      rd_chk(A_NS, 999_999_990, "R5");
      rd_chk(A_SEC, 13, "R5");
      rd_chk(A_PH, 0, "R5");

      // R6 load with phase
      wr(A_PH, 3); wr(A_NS, 100); wr(A_SEC, 1);
      cmd(32'h08);
      live_chk(1, 124, "R6");

      // R4 rate trim up then down
      wr(A_PH, 0); wr(A_NS, 0); wr(A_SEC, 0);
      cmd(32'h08);
      wr(A_RATE, 32'hA000_0000);
      cmd(32'h06);
      ticks(8);
      live_chk(0, 321, "R4 up");
      rd_chk(A_RATE, 32'hA000_0000, "R4");
      wr(A_RATE, 32'h2000_0000);
      ticks(8);
      live_chk(0, 640, "R4 down");
      cmd(32'h02);
      ticks(2);
      live_chk(0, 720, "R4 trim off");

      // R10 temporary rate for three ticks
      wr(A_DUR, 3);
      wr(A_RATE, 32'hE000_0000);
      rd_chk(A_RATE, 32'hE000_0000, "R10");
      ticks(3);
      live_chk(0, 840, "R10");
      rd_chk(A_RATE, 32'h2000_0000, "R10 revert");
      rd_chk(A_DUR, 0, "R10");
      ticks(5);
      live_chk(0, 1040, "R10 after");
      cmd(32'h06);
      ticks(1);
      live_chk(0, 1080, "R10 persistent");

      // R11 clock reset command
      cmd(32'h03);
      live_chk(0, 0, "R11");
      rd_chk(A_RATE, 0, "R11");
      rd_chk(A_CTRL, 32'h2, "R11");
      ticks(1);
      live_chk(0, 40, "R11 run kept");

      // R9 command timing and dropped tick
      wr(A_PH, 0); wr(A_NS, 500); wr(A_SEC, 2);
      tick = 1'b1;
      wr(A_CTRL, 32'h0A);
      live_chk(0, 80, "R9 before");
      @(negedge clk);
      live_chk(2, 500, "R9 after");
      tick = 1'b0;
      @(negedge clk);
      live_chk(2, 500, "R9 idle");

      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual hung expected finish");
         finish_run();
      end
   end

endmodule